// File: doc/BRIEF.md
# DLL calibration port sequencer

This block is a small bus master that programs a delay-line calibration unit through that unit's indirect register port. The port has a mode/address register, a start register, a write-data register and a read-data register. Next to them sits a separate phase-offset register. Every indirect access is a short run of single-word bus transfers. First the mode/address word is written. For a write, the data word follows. A start strobe is then written high and then low. For a read, the read-data register is fetched last.

Two fixed sequences are built from these accesses. The enable sequence starts by writing the unlock word. It then reads the unit's raw calibration code and looks that code up in a loadable table of 2^CODE_W entries. It writes the looked-up value back with the manual-mode bit set, and ends by writing the configured phase offset. The disable sequence writes the unlock word, clears the manual calibration register and zeroes the offset register, which returns the unit to automatic calibration. The enable sequence is armed by a pulse that marks entry into the double-data-rate 400 mode. It fires when a status-query command completes, but only if the feature is enabled and a table is loaded. A one-cycle done pulse marks the end of either sequence.

The master side is valid/ready. `port_valid` rises with the first transfer and stays high until the last transfer has been accepted. A transfer completes on a clock edge where `port_valid` and `port_ready` are both high. While `port_ready` is low, the block holds `port_sel`, `port_write` and `port_wdata` unchanged, so the target may stall any transfer for any number of cycles. `port_rdata` carries the low CODE_W bits of the read-data register and is sampled on the accepting edge of a read. ENTRY_W must not exceed 7, so that a table entry stays below the manual-mode bit.

Top module: `dllcal_seq`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `done` and `port_valid` are 0.
- R2: An indirect write of value V to address A is four transfers: select 0 (mode/address) with data {bit 8 = 0, A in bits 5:0}, select 2 (write-data) with V, select 1 (start) with 1, select 1 with 0. All four are writes.
- R3: An indirect read of address A is four transfers: select 0 with data 0x100 | A, select 1 with 1, select 1 with 0, then a read (port_write = 0) of select 3 (read-data). The low CODE_W bits of `port_rdata` on that read are kept as the raw code.
- R4: The enable sequence is 13 transfers: an indirect write of 0xA5000000 to address 0x00, an indirect read of 0x26, an indirect write of 0x80 | table[raw code] to 0x22, and finally a write of `offset_cfg` (sampled at launch) to select 4 (offset register).
- R5: The disable sequence is 9 transfers: an indirect write of 0xA5000000 to 0x00, an indirect write of 0 to 0x22, and a write of 0 to select 4.
- R6: An idle cycle with `status_cmd_done` high launches the enable sequence only if `feat_en`, `tbl_present` and the pending flag are all 1. Otherwise no transfer is issued.
- R7: A cycle with `hs_mode_enter` high sets the pending flag. Launching the enable sequence clears it. If both happen in the same cycle, the flag ends up set.
- R8: When `cal_disable_req` and an enable launch condition meet in the same idle cycle, only the disable sequence runs, and the pending flag is left as it was.
- R9: From the cycle after launch until its last transfer is accepted, `port_valid` stays high. While `port_ready` is low, `port_sel`, `port_write` and `port_wdata` stay stable.
- R10: `busy` is high from the cycle after launch through the cycle of the last accepted transfer. `done` is high for exactly the next cycle. Triggers that arrive while `busy` is high have no effect.
- R11: A table write (`tbl_wr_en`, `tbl_wr_idx`, `tbl_wr_data`) replaces one entry. A later enable sequence uses the entry held when its read transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Manual calibration feature enabled |
| tbl_present | input | 1 | A code table has been loaded |
| hs_mode_enter | input | 1 | Pulse: controller entered double-data-rate 400 mode, sets pending |
| status_cmd_done | input | 1 | Pulse: a status-query command completed, enable trigger |
| cal_disable_req | input | 1 | Pulse: run the disable sequence |
| offset_cfg | input | OFS_W | Phase offset written at the end of the enable sequence |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_idx | input | CODE_W | Table entry index |
| tbl_wr_data | input | ENTRY_W | Table entry value |
| port_valid | output | 1 | Transfer request |
| port_ready | input | 1 | Target accepts the transfer |
| port_write | output | 1 | 1 = write, 0 = read |
| port_sel | output | 3 | Register select: 0 mode/address, 1 start, 2 write-data, 3 read-data, 4 offset |
| port_wdata | output | 32 | Write data |
| port_rdata | input | CODE_W | Low bits of the read-data register |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse after a sequence completes |

## Verification
The bench first runs the enable sequence with `port_ready` tied high. This shows the transfer order and data with no stalls, so an error in the step decode cannot hide behind back-pressure. Later runs throttle `port_ready` pseudo-randomly. These show whether the held select and data survive stalls, and whether the captured raw code is taken on the accepting read edge and not earlier. The trigger patterns are each of the three enable conditions missing in turn, a repeated status pulse after pending has been consumed, a disable and an enable trigger in the same cycle, an arming pulse on the launch cycle, and triggers fired into a running sequence. Together these separate the gating, the priority and the pending set/clear order. The two raw codes cover a mid-table index and the top index, and a table rewrite between runs shows that the remap is read live and not cached.

// File: rtl/dllcal_pkg.sv
package dllcal_pkg;

  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;
  localparam int IDX_W  = 4;

  // indirect addresses and fixed words of the calibration unit
  localparam logic [5:0]        A_UNLOCK    = 6'h00;
  localparam logic [5:0]        A_RAW_CODE  = 6'h26;
  localparam logic [5:0]        A_MANUAL    = 6'h22;
  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'hA500_0000;
  localparam logic [DATA_W-1:0] RD_FLAG     = 32'h0000_0100;
  localparam logic [DATA_W-1:0] MANUAL_BIT  = 32'h0000_0080;

  // index of the final (offset) step of each sequence
  localparam logic [IDX_W-1:0] EN_LAST  = IDX_W'(12);
  localparam logic [IDX_W-1:0] DIS_LAST = IDX_W'(8);

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_START = 3'd1,
    SEL_WDATA = 3'd2,
    SEL_RDATA = 3'd3,
    SEL_OFS   = 3'd4
  } sel_e;

  typedef enum logic {
    SEQ_EN  = 1'b0,
    SEQ_DIS = 1'b1
  } seq_e;

  typedef enum logic [1:0] {
    DK_CONST = 2'd0,
    DK_MAP   = 2'd1,
    DK_OFS   = 2'd2
  } kind_e;

  typedef struct packed {
    sel_e              sel;
    logic              wr;
    kind_e             kind;
    logic [DATA_W-1:0] val;
    logic              last;
    logic              capture;
  } step_t;

endpackage

// File: rtl/dllcal_lut.sv
module dllcal_lut #(
  parameter int IDX_W   = 5,
  parameter int ENTRY_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] ent [DEPTH];
  logic [DEPTH-1:0]   we;

  // one decoded write strobe per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign we[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we[i]) ent[i] <= wr_data;
      end
    end
  end

  assign rd_data = ent[rd_idx];

  // R11
  lut_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/dllcal_trig.sv
module dllcal_trig
  import dllcal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic feat_en,
  input  logic tbl_present,
  input  logic hs_enter,
  input  logic stat_done,
  input  logic dis_req,
  output logic launch,
  output seq_e launch_seq
);
  logic pending_q;
  logic en_ok;
  logic en_launch;

  assign en_ok      = stat_done && feat_en && tbl_present && pending_q;
  assign launch     = idle && (dis_req || en_ok);
  assign launch_seq = dis_req ? SEQ_DIS : SEQ_EN;
  assign en_launch  = idle && !dis_req && en_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= 1'b0;
    else if (hs_enter)  pending_q <= 1'b1;
    else if (en_launch) pending_q <= 1'b0;
  end

  // R7
  arm_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enter |=> pending_q);

  // R7
  launch_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && launch_seq == SEQ_EN && !hs_enter) |=> !pending_q);

  // R8
  disable_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && dis_req && !hs_enter) |=> pending_q == $past(pending_q));

endmodule

// File: rtl/dllcal_plan.sv
module dllcal_plan
  import dllcal_pkg::*;
(
  input  seq_e             seq,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  logic [1:0]        op;
  logic [1:0]        sub;
  logic [5:0]        addr;
  logic              rd_op;
  logic [IDX_W-1:0]  last_idx;
  kind_e             wkind;
  logic [DATA_W-1:0] wval;

  always_comb begin
    op       = idx[IDX_W-1:2];
    sub      = idx[1:0];
    last_idx = (seq == SEQ_EN) ? EN_LAST : DIS_LAST;
    rd_op    = (seq == SEQ_EN) && (op == 2'd1);

    if (op == 2'd0)  addr = A_UNLOCK;
    else if (rd_op)  addr = A_RAW_CODE;
    else             addr = A_MANUAL;

    if (op == 2'd0) begin
      wkind = DK_CONST;
      wval  = UNLOCK_WORD;
    end else if (seq == SEQ_EN) begin
      wkind = DK_MAP;
      wval  = '0;
    end else begin
      wkind = DK_CONST;
      wval  = '0;
    end

    step         = '0;
    step.sel     = SEL_CTRL;
    step.wr      = 1'b1;
    step.kind    = DK_CONST;
    step.last    = (idx == last_idx);
    step.capture = 1'b0;

    if (idx == last_idx) begin
      step.sel  = SEL_OFS;
      step.kind = (seq == SEQ_EN) ? DK_OFS : DK_CONST;
      step.val  = '0;
    end else if (rd_op) begin
      case (sub)
        2'd0: begin step.sel = SEL_CTRL;  step.val = RD_FLAG | DATA_W'(addr); end
        2'd1: begin step.sel = SEL_START; step.val = DATA_W'(1); end
        2'd2: begin step.sel = SEL_START; step.val = '0; end
        default: begin
          step.sel     = SEL_RDATA;
          step.wr      = 1'b0;
          step.capture = 1'b1;
        end
      endcase
    end else begin
      case (sub)
        2'd0: begin step.sel = SEL_CTRL;  step.val = DATA_W'(addr); end
        2'd1: begin step.sel = SEL_WDATA; step.kind = wkind; step.val = wval; end
        2'd2: begin step.sel = SEL_START; step.val = DATA_W'(1); end
        default: begin step.sel = SEL_START; step.val = '0; end
      endcase
    end
  end

endmodule

// File: rtl/dllcal_seq.sv
module dllcal_seq
  import dllcal_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter int ENTRY_W = 7,
  parameter int OFS_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               feat_en,
  input  logic               tbl_present,
  input  logic               hs_mode_enter,
  input  logic               status_cmd_done,
  input  logic               cal_disable_req,
  input  logic [OFS_W-1:0]   offset_cfg,
  input  logic               tbl_wr_en,
  input  logic [CODE_W-1:0]  tbl_wr_idx,
  input  logic [ENTRY_W-1:0] tbl_wr_data,
  output logic               port_valid,
  input  logic               port_ready,
  output logic               port_write,
  output logic [SEL_W-1:0]   port_sel,
  output logic [DATA_W-1:0]  port_wdata,
  input  logic [CODE_W-1:0]  port_rdata,
  output logic               busy,
  output logic               done
);
  logic               busy_q;
  logic               done_q;
  seq_e               seq_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ENTRY_W-1:0] map_q;
  logic [OFS_W-1:0]   ofs_q;
  logic               launch;
  seq_e               launch_seq;
  logic [ENTRY_W-1:0] lut_rd;
  step_t              step;
  logic               xfer;

  dllcal_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (!busy_q),
    .feat_en    (feat_en),
    .tbl_present(tbl_present),
    .hs_enter   (hs_mode_enter),
    .stat_done  (status_cmd_done),
    .dis_req    (cal_disable_req),
    .launch     (launch),
    .launch_seq (launch_seq)
  );

  dllcal_lut #(.IDX_W(CODE_W), .ENTRY_W(ENTRY_W)) u_lut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr_en),
    .wr_idx (tbl_wr_idx),
    .wr_data(tbl_wr_data),
    .rd_idx (port_rdata),
    .rd_data(lut_rd)
  );

  dllcal_plan u_plan (
    .seq (seq_q),
    .idx (idx_q),
    .step(step)
  );

  assign xfer = busy_q && port_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      seq_q  <= SEQ_EN;
      idx_q  <= '0;
      map_q  <= '0;
      ofs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (launch) begin
          busy_q <= 1'b1;
          seq_q  <= launch_seq;
          idx_q  <= '0;
          ofs_q  <= offset_cfg;
        end
      end else if (xfer) begin
        if (step.capture) map_q <= lut_rd;
        if (step.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (step.kind)
      DK_MAP:  port_wdata = MANUAL_BIT | DATA_W'(map_q);
      DK_OFS:  port_wdata = DATA_W'(ofs_q);
      default: port_wdata = step.val;
    endcase
  end

  assign port_valid = busy_q;
  assign port_write = step.wr;
  assign port_sel   = step.sel;
  assign busy       = busy_q;
  assign done       = done_q;

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && !port_ready) |=> port_valid && $stable(port_sel)
      && $stable(port_write) && $stable(port_wdata));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && $past(port_ready));

  // R6
  start_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cal_disable_req || status_cmd_done));

  // R2
  strobe_is_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && port_sel == SEL_START) |-> port_write && port_wdata[DATA_W-1:1] == '0);

endmodule

// File: tb/dllcal_seq_tb.sv
`timescale 1ns/1ps
module dllcal_seq_tb;
  localparam int CW = 5;
  localparam int EW = 7;
  localparam int OW = 2;
  localparam int WD = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          feat_en = 1'b0, tbl_present = 1'b0;
  logic          hs_mode_enter = 1'b0, status_cmd_done = 1'b0, cal_disable_req = 1'b0;
  logic [OW-1:0] offset_cfg = '0;
  logic          tbl_wr_en = 1'b0;
  logic [CW-1:0] tbl_wr_idx = '0;
  logic [EW-1:0] tbl_wr_data = '0;
  logic          port_valid, port_ready, port_write, busy, done;
  logic [2:0]    port_sel;
  logic [31:0]   port_wdata;
  logic [CW-1:0] port_rdata;
  logic          rdy_rand = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;

  always #10 clk = ~clk;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign port_ready = rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1;

  dllcal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .tbl_present(tbl_present),
    .hs_mode_enter(hs_mode_enter), .status_cmd_done(status_cmd_done),
    .cal_disable_req(cal_disable_req), .offset_cfg(offset_cfg),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .port_valid(port_valid), .port_ready(port_ready), .port_write(port_write),
    .port_sel(port_sel), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .busy(busy), .done(done)
  );

  // ---------------- reference model ----------------
  typedef struct {
    int          sel;
    bit          wr;
    bit          rdop;
    logic [31:0] data;
  } acc_t;

  acc_t        q[$];
  logic [31:0] rf [64];
  logic [31:0] u_ctrl, u_wd, u_rd, u_ofs;
  bit          u_prev;
  logic [EW-1:0] tbl_m [32];
  bit          m_busy, m_done, m_pend;
  string       m_tag;
  int          n_chk, n_err, cyc, n_acc;

  assign port_rdata = u_rd[CW-1:0];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic push_write(input logic [5:0] a, input logic [31:0] v);
    q.push_back('{0, 1'b1, 1'b0, {26'b0, a}});
    q.push_back('{2, 1'b1, 1'b0, v});
    q.push_back('{1, 1'b1, 1'b0, 32'd1});
    q.push_back('{1, 1'b1, 1'b0, 32'd0});
  endtask

  task automatic push_read(input logic [5:0] a);
    q.push_back('{0, 1'b1, 1'b1, 32'h100 | {26'b0, a}});
    q.push_back('{1, 1'b1, 1'b1, 32'd1});
    q.push_back('{1, 1'b1, 1'b1, 32'd0});
    q.push_back('{3, 1'b0, 1'b1, 32'd0});
  endtask

  function automatic logic [31:0] exp_manual();
    logic [4:0] c;
    c = rf[6'h26][4:0];
    return 32'h80 | {25'b0, tbl_m[c]};
  endfunction

  task automatic unit_access();
    n_acc++;
    if (port_write) begin
      case (port_sel)
        3'd0: u_ctrl = port_wdata;
        3'd2: u_wd   = port_wdata;
        3'd4: u_ofs  = port_wdata;
        3'd1: begin
          if (port_wdata[0] && !u_prev) begin
            if (u_ctrl[8]) u_rd = rf[u_ctrl[5:0]];
            else           rf[u_ctrl[5:0]] = u_wd;
          end
          u_prev = port_wdata[0];
        end
        default: ;
      endcase
    end
  endtask

  always @(negedge clk) begin
    bit nb, nd;
    cyc++;
    if (cyc > WD) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, WD);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
    if (!rst_n) begin
      // R1 reset state
      chk("R1", busy, 0); chk("R1", done, 0); chk("R1", port_valid, 0);
      q.delete(); m_busy = 0; m_done = 0; m_pend = 0;
      for (int i = 0; i < 32; i++) tbl_m[i] = '0;
    end else begin
      chk("R10", busy, m_busy);
      chk("R10", done, m_done);
      chk("R9", port_valid, m_busy);
      if (m_busy && q.size() > 0) begin
        if (q[0].rdop) begin
          chk("R3", port_sel, q[0].sel); chk("R3", port_write, q[0].wr);
        end else begin
          chk("R2", port_sel, q[0].sel); chk("R2", port_write, q[0].wr);
        end
        if (q[0].wr) chk(m_tag, port_wdata, q[0].data);
      end
      nb = m_busy; nd = 0;
      if (m_busy) begin
        if (port_ready) begin
          unit_access();
          void'(q.pop_front());
          if (q.size() == 0) begin nb = 0; nd = 1; end
        end
      end else if (cal_disable_req) begin
        push_write(6'h00, 32'hA500_0000);
        push_write(6'h22, 32'h0);
        q.push_back('{4, 1'b1, 1'b0, 32'h0});
        nb = 1; m_tag = "R5";
      end else if (status_cmd_done && feat_en && tbl_present && m_pend) begin
        push_write(6'h00, 32'hA500_0000);
        push_read(6'h26);
        push_write(6'h22, exp_manual());
        q.push_back('{4, 1'b1, 1'b0, {30'b0, offset_cfg}});
        nb = 1; m_pend = 0; m_tag = "R4";
      end
      if (hs_mode_enter) m_pend = 1;
      if (tbl_wr_en) tbl_m[tbl_wr_idx] = tbl_wr_data;
      m_busy = nb; m_done = nd;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_quiet();
    tick();
    while (m_busy || m_done) tick();
  endtask

  task automatic p_arm();    hs_mode_enter = 1;   tick(); hs_mode_enter = 0;   endtask
  task automatic p_status(); status_cmd_done = 1; tick(); status_cmd_done = 0; endtask
  task automatic p_disable(); cal_disable_req = 1; tick(); cal_disable_req = 0; endtask

  task automatic load_entry(input int i, input logic [EW-1:0] v);
    tbl_wr_en = 1; tbl_wr_idx = CW'(i); tbl_wr_data = v; tick(); tbl_wr_en = 0;
  endtask

  initial begin
    int acc0;
    for (int i = 0; i < 64; i++) rf[i] = 32'h5A5A_0000 | i;
    rf[6'h26] = 32'hFFFF_FF00 | 32'h0D;
    u_ctrl = 0; u_wd = 0; u_rd = 0; u_ofs = 32'hF; u_prev = 0;
    n_chk = 0; n_err = 0; cyc = 0; n_acc = 0;
    repeat (4) tick();
    rst_n = 1;
    tick();
    chk("R1", busy, 0); chk("R1", port_valid, 0);

    for (int i = 0; i < 32; i++) load_entry(i, EW'((i * 3 + 1) & 7'h7F));

    // R6: no pending yet
    feat_en = 1; tbl_present = 1; offset_cfg = 2'd2;
    acc0 = n_acc; p_status(); wait_quiet();
    chk("R6", n_acc, acc0);

    // R6: feature disabled / table absent
    p_arm();
    feat_en = 0; acc0 = n_acc; p_status(); wait_quiet(); chk("R6", n_acc, acc0);
    feat_en = 1; tbl_present = 0; p_status(); wait_quiet(); chk("R6", n_acc, acc0);
    tbl_present = 1;

    // R4: full enable, no stall
    p_status(); wait_quiet();
    chk("R4", n_acc, acc0 + 13);
    chk("R4", rf[6'h00], 32'hA500_0000);
    chk("R4", rf[6'h22], 32'h80 | ((13 * 3 + 1) & 32'h7F));
    chk("R4", u_ofs, 32'd2);

    // R7: pending consumed
    acc0 = n_acc; p_status(); wait_quiet(); chk("R7", n_acc, acc0);

    // R10 + R9: stalled enable, triggers during busy ignored, top index
    rf[6'h26] = 32'h0000_001F; rdy_rand = 1; offset_cfg = 2'd3;
    p_arm(); p_status();
    p_disable(); p_status();
    wait_quiet();
    chk("R10", rf[6'h22], 32'h80 | ((31 * 3 + 1) & 32'h7F));
    chk("R9", u_ofs, 32'd3);

    // R5: disable under stalls
    p_disable(); wait_quiet();
    chk("R5", rf[6'h22], 32'h0);
    chk("R5", u_ofs, 32'h0);
    chk("R5", rf[6'h00], 32'hA500_0000);

    // R8: disable wins, pending survives
    p_arm(); offset_cfg = 2'd1;
    cal_disable_req = 1; status_cmd_done = 1; tick();
    cal_disable_req = 0; status_cmd_done = 0;
    wait_quiet();
    chk("R8", rf[6'h22], 32'h0);
    p_status(); wait_quiet();
    chk("R8", rf[6'h22], 32'h80 | ((31 * 3 + 1) & 32'h7F));
    chk("R8", u_ofs, 32'd1);

    // R7: arm in launch cycle keeps pending set
    p_arm();
    hs_mode_enter = 1; status_cmd_done = 1; tick();
    hs_mode_enter = 0; status_cmd_done = 0;
    wait_quiet();
    acc0 = n_acc; p_status(); wait_quiet();
    chk("R7", n_acc, acc0 + 13);

    // R11: table rewrite is used by the next run
    load_entry(31, 7'h55); rdy_rand = 0; offset_cfg = 2'd0;
    p_arm(); p_status(); wait_quiet();
    chk("R11", rf[6'h22], 32'hD5);
    chk("R11", u_ofs, 32'd0);

    repeat (3) tick();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule